// File: doc/BRIEF.md
# Exception Entry Sequencer

This block runs exception entry for a small 8-bit processor with a 16-bit address space. It watches four sources: a reset line that must be held, an edge-latched non-maskable interrupt, a level-sensitive maskable interrupt, and a software-interrupt request from the instruction decoder. When it accepts a source, it takes over the memory port. For the three interrupt-style sources it first writes a seven-byte snapshot of the register file below the stack pointer and raises a request to set the interrupt mask. It then reads a two-byte vector from the top of memory and hands the new program counter and stack pointer back to the core.

Reset skips the stacking and goes straight to its vector. The interrupt-style sources start only on an instruction-boundary strobe from the core. The snapshot of the registers is taken in the cycle of acceptance, so the core may change its registers while the frame is being written. Memory reads return data one cycle after the address is presented.

Top module: `exc_entry_seq`

## Requirements
- R1: If `res_n_i` is sampled low on at least RST_HOLD (8) consecutive rising edges and is then sampled high, a reset entry starts at that edge. Reset entry makes no memory writes, reads the vector at FFFE (high byte) then FFFF (low byte), and reports source code 0.
- R2: A low pulse on `res_n_i` that spans fewer than RST_HOLD sampled edges starts no entry.
- R3: While `res_n_i` is low, `mask_set_o` is high. From the next cycle `busy_o` is low. Any sequence in progress is abandoned, and pending software or non-maskable requests are discarded.
- R4: A high-to-low transition of `nmi_n_i`, seen at two successive edges, latches a non-maskable request regardless of `mask_i`. The request is served once at a later boundary, however long the line stays low. The vector is at FFFC/FFFD and the source code is 1.
- R5: A maskable request is taken at a boundary edge only if `irq_n_i` was sampled low at the previous edge and `mask_i` (condition-code bit 4) is 0 at the boundary edge. The vector is at FFF8/FFF9 and the source code is 3.
- R6: A one-cycle `swi_req_i` pulse latches a software request. It is served at a later boundary from vector FFFA/FFFB with source code 2.
- R7: Stacking writes seven consecutive cycles to SP, SP-1, ..., SP-6. The bytes are PC[7:0], PC[15:8], X[7:0], X[15:8], A, B, CC, using the values present at the acceptance edge.
- R8: `mask_set_o` is high for exactly the one cycle between the last stacking write and the first vector read.
- R9: Vector reads assert `mem_re_o` for two cycles, first at the high-byte address and then at the low-byte address. The new PC is formed as {first returned byte, second returned byte}.
- R10: In the cycle after the second read's data returns, `pc_ld_o` and `done_o` pulse with `pc_new_o` and `done_src_o`. For non-reset sources, `sp_ld_o` pulses in the same cycle with `sp_new_o` = SP-7 (modulo 2^16).
- R11: Non-reset sources start only on an edge where `insn_end_i` is high and the block is idle. A strobe while busy is ignored. The priority order is reset, then NMI, then SWI, then IRQ.
- R12: `busy_o` is high from the cycle after acceptance through the PC-load cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| res_n_i | input | 1 | Processor reset line, active low |
| nmi_n_i | input | 1 | Non-maskable interrupt line, active low |
| irq_n_i | input | 1 | Maskable interrupt line, active low |
| swi_req_i | input | 1 | Software-interrupt request pulse from the decoder |
| insn_end_i | input | 1 | Instruction-boundary strobe |
| mask_i | input | 1 | Current interrupt mask bit (CC bit 4) |
| sp_i | input | 16 | Current stack pointer |
| pc_i | input | 16 | Return program counter |
| x_i | input | 16 | Index register |
| a_i | input | 8 | Accumulator A |
| b_i | input | 8 | Accumulator B |
| cc_i | input | 8 | Condition codes |
| mem_rdata_i | input | 8 | Read data, valid one cycle after a read |
| mem_addr_o | output | 16 | Memory address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_re_o | output | 1 | Memory read strobe |
| mask_set_o | output | 1 | Request to set the interrupt mask |
| busy_o | output | 1 | Entry sequence in progress |
| pc_ld_o | output | 1 | Load `pc_new_o` into the program counter |
| pc_new_o | output | 16 | Vector target |
| sp_ld_o | output | 1 | Load `sp_new_o` into the stack pointer |
| sp_new_o | output | 16 | Stack pointer after stacking |
| done_o | output | 1 | Entry complete pulse |
| done_src_o | output | 2 | Served source: 0 reset, 1 NMI, 2 SWI, 3 IRQ |

## Verification
The properties assume the memory answers every read with data one cycle later, and that the core holds `sp_i` steady only at the acceptance edge. They also assume `rst_n` starts low, so that registered state is known before any check is enabled. The stimulus changes every input shortly after the falling clock edge and feeds read data from a fixed function of the address. It drops the mask in the core's place only between boundaries, and it holds the interrupt lines long enough to be sampled at least once.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  typedef enum logic [1:0] {
    SRC_RST = 2'd0,
    SRC_NMI = 2'd1,
    SRC_SWI = 2'd2,
    SRC_IRQ = 2'd3
  } exc_src_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PUSH = 3'd1,
    ST_MASK = 3'd2,
    ST_VHI  = 3'd3,
    ST_VLO  = 3'd4,
    ST_VFIN = 3'd5,
    ST_LOAD = 3'd6
  } seq_st_e;
endpackage

// File: rtl/exc_src_qual.sv
`timescale 1ns/1ps
// Qualifies the four exception sources: reset hold count, NMI edge latch,
// SWI request latch and IRQ level sample.
module exc_src_qual #(
  parameter int RST_HOLD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic res_n_i,
  input  logic nmi_n_i,
  input  logic irq_n_i,
  input  logic swi_req_i,
  input  logic mask_i,
  input  logic clr_nmi_i,
  input  logic clr_swi_i,
  output logic res_act_o,
  output logic rst_start_o,
  output logic nmi_pend_o,
  output logic swi_pend_o,
  output logic irq_req_o
);
  localparam int CW = $clog2(RST_HOLD + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(RST_HOLD);

  logic [CW-1:0] rcnt_q, rcnt_d;
  logic          nmi_s_q, nmi_s_d;
  logic          irq_s_q, irq_s_d;
  logic          nmi_p_q, nmi_p_d;
  logic          swi_p_q, swi_p_d;
  logic          nmi_fall;

  assign nmi_fall = ~nmi_n_i & ~nmi_s_q;

  always_comb begin
    rcnt_d  = rcnt_q;
    nmi_p_d = nmi_p_q;
    swi_p_d = swi_p_q;
    nmi_s_d = ~nmi_n_i;
    irq_s_d = ~irq_n_i;
    if (!res_n_i) begin
      if (rcnt_q != HOLD_C) rcnt_d = rcnt_q + 1'b1;
      nmi_p_d = 1'b0;
      swi_p_d = 1'b0;
    end else begin
      rcnt_d = '0;
      if (nmi_fall)       nmi_p_d = 1'b1;
      else if (clr_nmi_i) nmi_p_d = 1'b0;
      if (swi_req_i)      swi_p_d = 1'b1;
      else if (clr_swi_i) swi_p_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q  <= '0;
      nmi_s_q <= 1'b0;
      irq_s_q <= 1'b0;
      nmi_p_q <= 1'b0;
      swi_p_q <= 1'b0;
    end else begin
      rcnt_q  <= rcnt_d;
      nmi_s_q <= nmi_s_d;
      irq_s_q <= irq_s_d;
      nmi_p_q <= nmi_p_d;
      swi_p_q <= swi_p_d;
    end
  end

  assign res_act_o   = ~res_n_i;
  assign rst_start_o = res_n_i & (rcnt_q == HOLD_C);
  assign nmi_pend_o  = nmi_p_q;
  assign swi_pend_o  = swi_p_q;
  assign irq_req_o   = irq_s_q & ~mask_i;
endmodule

// File: rtl/exc_frame.sv
`timescale 1ns/1ps
// Snapshot of the register frame taken at acceptance, read out byte by byte.
module exc_frame #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int NB = 7,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic          clr_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] x_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] cc_i,
  input  logic [IW-1:0] idx_i,
  output logic [DW-1:0] byte_o
);
  logic [NB*DW-1:0] frame_in;
  logic [DW-1:0]    slot_w [NB];

  // byte 0 is the first one written (PC low), byte NB-1 the last (CC)
  assign frame_in = {cc_i, b_i, a_i, x_i, pc_i};

  for (genvar k = 0; k < NB; k++) begin : g_slot
    logic [DW-1:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     byte_q <= '0;
      else if (clr_i) byte_q <= '0;
      else if (cap_i) byte_q <= frame_in[k*DW +: DW];
    end
    assign slot_w[k] = byte_q;
  end

  always_comb begin
    byte_o = '0;
    for (int k = 0; k < NB; k++) begin
      if (idx_i == IW'(k)) byte_o = slot_w[k];
    end
  end
endmodule

// File: rtl/exc_seq_fsm.sv
`timescale 1ns/1ps
// Sequencer: acceptance and priority, stacking, mask request, vector fetch, load.
module exc_seq_fsm
  import exc_pkg::*;
#(
  parameter int          AW      = 16,
  parameter int          DW      = 8,
  parameter int          NB      = 7,
  parameter int          IW      = 3,
  parameter logic [15:0] VEC_TOP = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_act_i,
  input  logic          rst_start_i,
  input  logic          nmi_pend_i,
  input  logic          swi_pend_i,
  input  logic          irq_req_i,
  input  logic          insn_end_i,
  input  logic [AW-1:0] sp_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] frame_byte_i,
  output logic          cap_o,
  output logic          clr_nmi_o,
  output logic          clr_swi_o,
  output logic [IW-1:0] idx_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_re_o,
  output logic          mask_set_o,
  output logic          busy_o,
  output logic          pc_ld_o,
  output logic [AW-1:0] pc_new_o,
  output logic          sp_ld_o,
  output logic [AW-1:0] sp_new_o,
  output logic          done_o,
  output logic [1:0]    done_src_o
);
  localparam logic [IW-1:0] LAST_IDX = IW'(NB - 1);
  localparam logic [AW-1:0] FRAME_SZ = AW'(NB);

  seq_st_e       st_q, st_d;
  exc_src_e      src_q, src_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [AW-1:0] sp_q, sp_d;
  logic [DW-1:0] vhi_q, vhi_d;
  logic [DW-1:0] vlo_q, vlo_d;
  logic [AW-1:0] vec_base;
  logic          any_req;

  assign any_req  = nmi_pend_i | swi_pend_i | irq_req_i;
  assign vec_base = VEC_TOP[AW-1:0] - AW'({src_q, 1'b0});

  always_comb begin
    st_d      = st_q;
    src_d     = src_q;
    idx_d     = idx_q;
    sp_d      = sp_q;
    vhi_d     = vhi_q;
    vlo_d     = vlo_q;
    cap_o     = 1'b0;
    clr_nmi_o = 1'b0;
    clr_swi_o = 1'b0;
    if (res_act_i) begin
      st_d  = ST_IDLE;
      src_d = SRC_RST;
      idx_d = '0;
      sp_d  = '0;
      vhi_d = '0;
      vlo_d = '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (rst_start_i) begin
            st_d  = ST_VHI;
            src_d = SRC_RST;
          end else if (insn_end_i && any_req) begin
            st_d  = ST_PUSH;
            idx_d = '0;
            sp_d  = sp_i;
            cap_o = 1'b1;
            if (nmi_pend_i) begin
              src_d     = SRC_NMI;
              clr_nmi_o = 1'b1;
            end else if (swi_pend_i) begin
              src_d     = SRC_SWI;
              clr_swi_o = 1'b1;
            end else begin
              src_d     = SRC_IRQ;
            end
          end
        end
        ST_PUSH: begin
          if (idx_q == LAST_IDX) st_d = ST_MASK;
          else                   idx_d = idx_q + 1'b1;
        end
        ST_MASK: st_d = ST_VHI;
        ST_VHI:  st_d = ST_VLO;
        ST_VLO: begin
          vhi_d = mem_rdata_i;
          st_d  = ST_VFIN;
        end
        ST_VFIN: begin
          vlo_d = mem_rdata_i;
          st_d  = ST_LOAD;
        end
        ST_LOAD: st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      src_q <= SRC_RST;
      idx_q <= '0;
      sp_q  <= '0;
      vhi_q <= '0;
      vlo_q <= '0;
    end else begin
      st_q  <= st_d;
      src_q <= src_d;
      idx_q <= idx_d;
      sp_q  <= sp_d;
      vhi_q <= vhi_d;
      vlo_q <= vlo_d;
    end
  end

  always_comb begin
    mem_addr_o = '0;
    case (st_q)
      ST_PUSH: mem_addr_o = sp_q - AW'(idx_q);
      ST_VHI:  mem_addr_o = vec_base;
      ST_VLO:  mem_addr_o = vec_base + 1'b1;
      default: mem_addr_o = '0;
    endcase
  end

  assign idx_o       = idx_q;
  assign mem_we_o    = (st_q == ST_PUSH);
  assign mem_wdata_o = (st_q == ST_PUSH) ? frame_byte_i : '0;
  assign mem_re_o    = (st_q == ST_VHI) | (st_q == ST_VLO);
  assign mask_set_o  = res_act_i | (st_q == ST_MASK);
  assign busy_o      = (st_q != ST_IDLE);
  assign pc_ld_o     = (st_q == ST_LOAD);
  assign done_o      = (st_q == ST_LOAD);
  assign pc_new_o    = {vhi_q, vlo_q};
  assign sp_ld_o     = (st_q == ST_LOAD) & (src_q != SRC_RST);
  assign sp_new_o    = sp_q - FRAME_SZ;
  assign done_src_o  = src_q;
endmodule

// File: rtl/exc_entry_seq.sv
`timescale 1ns/1ps
module exc_entry_seq #(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter int          RST_HOLD = 8,
  parameter logic [15:0] VEC_TOP  = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_n_i,
  input  logic          nmi_n_i,
  input  logic          irq_n_i,
  input  logic          swi_req_i,
  input  logic          insn_end_i,
  input  logic          mask_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] x_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] cc_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_re_o,
  output logic          mask_set_o,
  output logic          busy_o,
  output logic          pc_ld_o,
  output logic [AW-1:0] pc_new_o,
  output logic          sp_ld_o,
  output logic [AW-1:0] sp_new_o,
  output logic          done_o,
  output logic [1:0]    done_src_o
);
  localparam int NB = 2 * (AW / DW) + 3;
  localparam int IW = $clog2(NB);

  logic          res_act, rst_start, nmi_pend, swi_pend, irq_req;
  logic          cap, clr_nmi, clr_swi;
  logic [IW-1:0] idx;
  logic [DW-1:0] frame_byte;

  exc_src_qual #(.RST_HOLD(RST_HOLD)) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_n_i    (res_n_i),
    .nmi_n_i    (nmi_n_i),
    .irq_n_i    (irq_n_i),
    .swi_req_i  (swi_req_i),
    .mask_i     (mask_i),
    .clr_nmi_i  (clr_nmi),
    .clr_swi_i  (clr_swi),
    .res_act_o  (res_act),
    .rst_start_o(rst_start),
    .nmi_pend_o (nmi_pend),
    .swi_pend_o (swi_pend),
    .irq_req_o  (irq_req)
  );

  exc_frame #(.AW(AW), .DW(DW), .NB(NB), .IW(IW)) u_frame (
    .clk   (clk),
    .rst_n (rst_n),
    .cap_i (cap),
    .clr_i (res_act),
    .pc_i  (pc_i),
    .x_i   (x_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .cc_i  (cc_i),
    .idx_i (idx),
    .byte_o(frame_byte)
  );

  exc_seq_fsm #(.AW(AW), .DW(DW), .NB(NB), .IW(IW), .VEC_TOP(VEC_TOP)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .res_act_i   (res_act),
    .rst_start_i (rst_start),
    .nmi_pend_i  (nmi_pend),
    .swi_pend_i  (swi_pend),
    .irq_req_i   (irq_req),
    .insn_end_i  (insn_end_i),
    .sp_i        (sp_i),
    .mem_rdata_i (mem_rdata_i),
    .frame_byte_i(frame_byte),
    .cap_o       (cap),
    .clr_nmi_o   (clr_nmi),
    .clr_swi_o   (clr_swi),
    .idx_o       (idx),
    .mem_addr_o  (mem_addr_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_re_o    (mem_re_o),
    .mask_set_o  (mask_set_o),
    .busy_o      (busy_o),
    .pc_ld_o     (pc_ld_o),
    .pc_new_o    (pc_new_o),
    .sp_ld_o     (sp_ld_o),
    .sp_new_o    (sp_new_o),
    .done_o      (done_o),
    .done_src_o  (done_src_o)
  );
endmodule

// File: rtl/exc_entry_seq_chk.sv
`timescale 1ns/1ps
module exc_entry_seq_chk #(
  parameter int          AW      = 16,
  parameter logic [15:0] VEC_TOP = 16'hFFFE
) (
  input logic          clk,
  input logic          rst_n,
  input logic          res_n_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic          mask_set_o,
  input logic          busy_o,
  input logic          pc_ld_o,
  input logic          sp_ld_o,
  input logic          done_o,
  input logic [1:0]    done_src_o
);
  localparam logic [AW-1:0] VEC_LOW = VEC_TOP[AW-1:0] - AW'(6);
  localparam logic [AW-1:0] ONE     = AW'(1);

  AST_RESET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !res_n_i |-> mask_set_o); // R3
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !res_n_i |=> !busy_o); // R3
  AST_PUSH_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - ONE)); // R7
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o)); // R9
  AST_VEC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |-> (mem_addr_o >= VEC_LOW)); // R9
  AST_DONE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pc_ld_o && busy_o)); // R10
  AST_SP_NOT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    sp_ld_o |-> (done_src_o != 2'd0)); // R10
  AST_WE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o); // R12
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o); // R12
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.AW(AW), .VEC_TOP(VEC_TOP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .res_n_i    (res_n_i),
  .mem_addr_o (mem_addr_o),
  .mem_we_o   (mem_we_o),
  .mem_re_o   (mem_re_o),
  .mask_set_o (mask_set_o),
  .busy_o     (busy_o),
  .pc_ld_o    (pc_ld_o),
  .sp_ld_o    (sp_ld_o),
  .done_o     (done_o),
  .done_src_o (done_src_o)
);

// File: tb/exc_entry_seq_tb_top.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;
  localparam int HOLD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_n_i = 1'b0, nmi_n_i = 1'b1, irq_n_i = 1'b1;
  logic        swi_req_i = 1'b0, insn_end_i = 1'b0, mask_i = 1'b1;
  logic [15:0] sp_i = 16'h01F0, pc_i = 16'h1234, x_i = 16'h5678;
  logic [7:0]  a_i = 8'h9A, b_i = 8'hBC, cc_i = 8'hD0;
  logic [7:0]  mem_rdata_i = 8'h00;
  logic [15:0] mem_addr_o, pc_new_o, sp_new_o;
  logic        mem_we_o, mem_re_o, mask_set_o, busy_o, pc_ld_o, sp_ld_o, done_o;
  logic [7:0]  mem_wdata_o;
  logic [1:0]  done_src_o;

  always #4 clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .res_n_i(res_n_i), .nmi_n_i(nmi_n_i), .irq_n_i(irq_n_i),
    .swi_req_i(swi_req_i), .insn_end_i(insn_end_i), .mask_i(mask_i), .sp_i(sp_i),
    .pc_i(pc_i), .x_i(x_i), .a_i(a_i), .b_i(b_i), .cc_i(cc_i), .mem_rdata_i(mem_rdata_i),
    .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
    .mem_re_o(mem_re_o), .mask_set_o(mask_set_o), .busy_o(busy_o), .pc_ld_o(pc_ld_o),
    .pc_new_o(pc_new_o), .sp_ld_o(sp_ld_o), .sp_new_o(sp_new_o), .done_o(done_o),
    .done_src_o(done_src_o)
  );

  typedef struct {
    bit          busy, we, re, mask, ld, spld;
    logic [15:0] addr, spn, pcn;
    logic [7:0]  wd;
    logic [1:0]  src;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  int   cnt_src[4] = '{0, 0, 0, 0};
  bit   last_busy = 0, nmi_p = 0, swi_p = 0, nmi_s = 0, irq_s = 0;
  int   rcnt = 0;
  logic [7:0] nxt_rd = 8'h00;

  function automatic logic [7:0] vbyte(logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t blank();
    exp_t e;
    e.busy = 0; e.we = 0; e.re = 0; e.mask = 0; e.ld = 0; e.spld = 0;
    e.addr = '0; e.spn = '0; e.pcn = '0; e.wd = '0; e.src = '0;
    return e;
  endfunction

  // behavioural plan of one entry, queued cycle by cycle
  function automatic void enq(int src);
    exp_t e;
    logic [15:0] base;
    logic [7:0]  fr[7];
    base = 16'hFFFE - 16'(2 * src);
    fr[0] = pc_i[7:0]; fr[1] = pc_i[15:8]; fr[2] = x_i[7:0]; fr[3] = x_i[15:8];
    fr[4] = a_i; fr[5] = b_i; fr[6] = cc_i;
    if (src != 0) begin
      for (int i = 0; i < 7; i++) begin
        e = blank(); e.busy = 1; e.we = 1; e.addr = sp_i - 16'(i); e.wd = fr[i];
        q.push_back(e);
      end
      e = blank(); e.busy = 1; e.mask = 1; q.push_back(e);
    end
    e = blank(); e.busy = 1; e.re = 1; e.addr = base; q.push_back(e);
    e = blank(); e.busy = 1; e.re = 1; e.addr = base + 16'd1; q.push_back(e);
    e = blank(); e.busy = 1; q.push_back(e);
    e = blank(); e.busy = 1; e.ld = 1; e.src = 2'(src);
    e.pcn = {vbyte(base), vbyte(base + 16'd1)};
    e.spld = (src != 0); e.spn = sp_i - 16'd7;
    q.push_back(e);
  endfunction

  // reference model, advanced on each rising edge from the inputs
  always @(posedge clk) begin
    bit irq_ok, nmi_edge;
    if (!rst_n) begin
      q.delete(); nmi_p = 0; swi_p = 0; rcnt = 0; nmi_s = 0; irq_s = 0; last_busy = 0;
    end else begin
      irq_ok   = irq_s && !mask_i;
      nmi_edge = !nmi_n_i && !nmi_s;
      if (!res_n_i) begin
        q.delete(); nmi_p = 0; swi_p = 0;
        if (rcnt < HOLD) rcnt++;
      end else begin
        if (rcnt == HOLD) enq(0);
        else if (!last_busy && insn_end_i) begin
          if (nmi_p) begin enq(1); nmi_p = 0; end
          else if (swi_p) begin enq(2); swi_p = 0; end
          else if (irq_ok) enq(3);
        end
        rcnt = 0;
        if (nmi_edge) nmi_p = 1;
        if (swi_req_i) swi_p = 1;
      end
      nmi_s = !nmi_n_i;
      irq_s = !irq_n_i;
    end
  end

  always @(negedge clk) if (mem_re_o) nxt_rd = vbyte(mem_addr_o);
  always @(posedge clk) mem_rdata_i <= nxt_rd;

  // per-cycle comparison against the model
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      e = (q.size() > 0) ? q.pop_front() : blank();
      chk("R12 busy_o", 32'(busy_o), 32'(e.busy));
      chk("R7 mem_we_o", 32'(mem_we_o), 32'(e.we));
      chk("R9 mem_re_o", 32'(mem_re_o), 32'(e.re));
      chk("R8/R3 mask_set_o", 32'(mask_set_o), 32'(e.mask | !res_n_i));
      chk("R10 pc_ld_o", 32'(pc_ld_o), 32'(e.ld));
      chk("R10 done_o", 32'(done_o), 32'(e.ld));
      chk("R10 sp_ld_o", 32'(sp_ld_o), 32'(e.spld));
      if (e.we) begin
        chk("R7 push address", 32'(mem_addr_o), 32'(e.addr));
        chk("R7 push data", 32'(mem_wdata_o), 32'(e.wd));
      end
      if (e.re) chk("R9 vector address", 32'(mem_addr_o), 32'(e.addr));
      if (e.ld) begin
        chk("R9/R10 pc_new_o", 32'(pc_new_o), 32'(e.pcn));
        chk("R11 done_src_o", 32'(done_src_o), 32'(e.src));
      end
      if (e.spld) chk("R10 sp_new_o", 32'(sp_new_o), 32'(e.spn));
      last_busy = e.busy;
      if (done_o) cnt_src[done_src_o]++;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic boundary();
    insn_end_i = 1'b1; step(1); insn_end_i = 1'b0;
  endtask

  task automatic new_regs();
    sp_i = 16'($urandom); pc_i = 16'($urandom); x_i = 16'($urandom);
    a_i = 8'($urandom); b_i = 8'($urandom); cc_i = 8'($urandom);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3);
    chk("R3 reset state busy_o", 32'(busy_o), 32'd0);
    chk("R3 reset state mem_we_o", 32'(mem_we_o), 32'd0);
    chk("R3 reset state mask_set_o", 32'(mask_set_o), 32'd1);
    rst_n = 1'b1;
    // R1: long reset, then reset entry
    step(10); res_n_i = 1'b1; step(6);
    chk("R1 reset entries", 32'(cnt_src[0]), 32'd1);
    // R2, R3: latched NMI then a short reset pulse: both dropped
    nmi_n_i = 1'b0; step(2);
    res_n_i = 1'b0; step(3); res_n_i = 1'b1; step(2);
    boundary(); step(14);
    chk("R2 no reset entry from short pulse", 32'(cnt_src[0]), 32'd1);
    chk("R3 pending NMI discarded", 32'(cnt_src[1]), 32'd0);
    nmi_n_i = 1'b1; step(2);
    // R4: NMI with mask set, line held low across two boundaries
    new_regs(); mask_i = 1'b1; nmi_n_i = 1'b0; step(2);
    boundary(); step(14); boundary(); step(14);
    chk("R4 one NMI entry per edge", 32'(cnt_src[1]), 32'd1);
    nmi_n_i = 1'b1; step(2);
    // R5: IRQ blocked by mask, then taken
    new_regs(); irq_n_i = 1'b0; step(2); boundary(); step(14);
    chk("R5 IRQ masked", 32'(cnt_src[3]), 32'd0);
    mask_i = 1'b0; boundary(); mask_i = 1'b1; step(14);
    chk("R5 IRQ taken", 32'(cnt_src[3]), 32'd1);
    irq_n_i = 1'b1; step(2);
    // R6, R7: SWI with registers changing during stacking; strobe while busy
    new_regs(); swi_req_i = 1'b1; step(1); swi_req_i = 1'b0; step(1);
    boundary(); new_regs(); step(3); boundary(); step(12);
    chk("R6 SWI entry", 32'(cnt_src[2]), 32'd1);
    // R11: all three pending at one boundary
    new_regs(); nmi_n_i = 1'b0; swi_req_i = 1'b1; irq_n_i = 1'b0; mask_i = 1'b0; step(1);
    swi_req_i = 1'b0; step(1);
    boundary(); step(14);
    chk("R11 NMI first", 32'(cnt_src[1]), 32'd2);
    new_regs(); boundary(); step(14);
    chk("R11 SWI second", 32'(cnt_src[2]), 32'd2);
    boundary(); mask_i = 1'b1; step(14);
    chk("R11 IRQ last", 32'(cnt_src[3]), 32'd2);
    nmi_n_i = 1'b1; irq_n_i = 1'b1; step(2);
    // R3: reset in the middle of stacking, then R1 reset entry
    new_regs(); swi_req_i = 1'b1; step(1); swi_req_i = 1'b0; step(1);
    boundary(); step(3);
    res_n_i = 1'b0; step(9); res_n_i = 1'b1; step(6);
    chk("R3 aborted SWI not completed", 32'(cnt_src[2]), 32'd2);
    chk("R1 reset entry after abort", 32'(cnt_src[0]), 32'd2);
    step(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule